// File: doc/BRIEF.md
# Circular Capture Buffer Controller

This block sits behind a bank of sampling channels. It keeps every channel's most recent samples in a circular memory of 1024 cells. All channels share one write position, and that position advances on each valid sample. When a trigger is accepted, the write position is frozen for every channel at the same moment. The controller then copies a window of the selected record length into a multi-event store. The window is the run of cells that ends with the newest sample written before the trigger, taken oldest first. A shorter record length gives a proportionally shorter copy phase, so the block is dead for fewer cycles.

The store holds up to seven complete events. If an event does not fit, because all seven descriptor slots are taken or because there are too few free words, the trigger is refused and a saturating lost-trigger counter advances. Triggers that arrive during a copy are ignored altogether. A consumer drains events word by word through a registered read port, and the last word of each event is flagged. When the copy ends, sampling continues from the frozen position, so the new data follow on directly from the captured history.

Top module: `ring_capture_ctrl`

## Requirements
- R1: After reset the write position is cell 0. Each valid sample that arrives while the block is not busy is stored at the write position in every channel, and the position then advances by one modulo 1024.
- R2: An accepted trigger with effective length L yields an event of L words. Those words are the last L samples written before the trigger, oldest first, and the window wraps from cell 1023 to cell 0 when needed. Channel c occupies bits [12c+11:12c] of each word.
- R3: A record length of 0, or any value above 1024, is treated as 1024.
- R4: `busy` rises in the cycle after an accepted trigger and stays high for exactly L cycles. Samples presented while `busy` is high are discarded.
- R5: A trigger presented while `busy` is high has no effect. It creates no event and leaves `lost_cnt` unchanged.
- R6: A trigger is refused when seven events are already stored, or when the free store words are fewer than L. A refused trigger does not raise `busy` and adds one to `lost_cnt`, which saturates at its maximum.
- R7: `evt_ready` is high whenever at least one complete event is stored. It rises in the cycle after the last word of a copy and falls only after the last word of the last stored event has been read.
- R8: When `rd_req` is high while `evt_ready` is high, the next cycle shows `rd_valid` with the next stored word. `rd_last` marks the final word of each event. Events leave the store in capture order, and `rd_valid` stays low in the cycle after any request that was not served.
- R9: After a copy, sampling resumes at the frozen write position with no gap in the sample history.
- R10: After reset, `busy`, `evt_ready`, `rd_valid` and `lost_cnt` are all zero.
- R11: A sample presented in the same cycle as an accepted trigger is discarded. A sample presented with a refused trigger is stored as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample strobe for all channels |
| s_data | input | NUM_CH*SAMPLE_W | Packed samples, channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| trig | input | 1 | Trigger request |
| rec_len | input | clog2(DEPTH)+1 | Record length in words, 0 selects full depth |
| rd_req | input | 1 | Request one word from the event store |
| busy | output | 1 | Dead-time flag, high while a window is being copied |
| evt_ready | output | 1 | At least one complete event is stored |
| rd_valid | output | 1 | rd_data holds a stored word |
| rd_data | output | NUM_CH*SAMPLE_W | Stored word, same packing as s_data |
| rd_last | output | 1 | Final word of the current event |
| lost_cnt | output | LOST_W | Saturating count of refused triggers |

## Verification
The hardest state to reach from the ports is a capture window that straddles the end of the ring while the store is close to a limit. The stimulus pushes ramp samples until the write position sits just past cell 0, then triggers with a length that wraps. Separately, it fills either all seven descriptor slots with short events or the whole word capacity with two full-depth events, and then triggers once more. Random runs of sample bursts, lengths, in-cycle samples, triggers during dead time and partial drains cover the remaining combinations. Each output word is checked against the sample index the ramp placed there.

// File: rtl/ring_capture_pkg.sv
package ring_capture_pkg;

   typedef enum logic [0:0] {
      CAP_SAMPLE = 1'b0,
      CAP_COPY   = 1'b1
   } cap_state_e;

endpackage

// File: rtl/ring_bank.sv
module ring_bank #(
   parameter int NUM_CH   = 2,
   parameter int SAMPLE_W = 12,
   parameter int DEPTH    = 1024
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [$clog2(DEPTH)-1:0]     wr_addr,
   input  logic [NUM_CH*SAMPLE_W-1:0]   wr_data,
   input  logic [$clog2(DEPTH)-1:0]     rd_addr,
   output logic [NUM_CH*SAMPLE_W-1:0]   rd_data
);

   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
         logic [SAMPLE_W-1:0] cells [DEPTH];

         always_ff @(posedge clk) begin
            if (wr_en) begin
               cells[wr_addr] <= wr_data[ch*SAMPLE_W +: SAMPLE_W];
            end
         end

         assign rd_data[ch*SAMPLE_W +: SAMPLE_W] = cells[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/capture_fsm.sv
module capture_fsm
   import ring_capture_pkg::*;
#(
   parameter int DEPTH       = 1024,
   parameter int NUM_EVT     = 7,
   parameter int STORE_WORDS = 2048,
   parameter int LOST_W      = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               s_valid,
   input  logic                               trig,
   input  logic [$clog2(DEPTH):0]             rec_len,
   input  logic [$clog2(NUM_EVT+1)-1:0]       evt_cnt,
   input  logic [$clog2(STORE_WORDS):0]       free_words,
   output logic                               ring_we,
   output logic [$clog2(DEPTH)-1:0]           ring_waddr,
   output logic [$clog2(DEPTH)-1:0]           ring_raddr,
   output logic                               busy,
   output logic                               copy_we,
   output logic                               commit,
   output logic [$clog2(DEPTH):0]             commit_len,
   output logic [LOST_W-1:0]                  lost_cnt
);

   localparam int AW    = $clog2(DEPTH);
   localparam int LEN_W = AW + 1;
   localparam int FW    = $clog2(STORE_WORDS) + 1;
   localparam int EW    = $clog2(NUM_EVT + 1);
   localparam logic [LOST_W-1:0] LOST_MAX = '1;

   cap_state_e         state;
   logic [AW-1:0]      wr_pos;
   logic [AW-1:0]      rd_pos;
   logic [LEN_W-1:0]   remaining;
   logic [LEN_W-1:0]   len_hold;
   logic [LEN_W-1:0]   len_eff;
   logic               room_ok;
   logic               take;

   always_comb begin
      if (rec_len == '0 || rec_len > LEN_W'(DEPTH)) begin
         len_eff = LEN_W'(DEPTH);
      end else begin
         len_eff = rec_len;
      end
   end

   assign room_ok = (evt_cnt < EW'(NUM_EVT)) && (free_words >= FW'(len_eff));
   assign take    = (state == CAP_SAMPLE) && trig && room_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CAP_SAMPLE;
         wr_pos    <= '0;
         rd_pos    <= '0;
         remaining <= '0;
         len_hold  <= '0;
         lost_cnt  <= '0;
      end else begin
         case (state)
            CAP_SAMPLE: begin
               if (take) begin
                  state     <= CAP_COPY;
                  rd_pos    <= wr_pos - len_eff[AW-1:0];
                  remaining <= len_eff;
                  len_hold  <= len_eff;
               end else begin
                  if (s_valid) begin
                     wr_pos <= wr_pos + AW'(1);
                  end
                  if (trig && lost_cnt != LOST_MAX) begin
                     lost_cnt <= lost_cnt + LOST_W'(1);
                  end
               end
            end
            CAP_COPY: begin
               rd_pos    <= rd_pos + AW'(1);
               remaining <= remaining - LEN_W'(1);
               if (remaining == LEN_W'(1)) begin
                  state <= CAP_SAMPLE;
               end
            end
            default: state <= CAP_SAMPLE;
         endcase
      end
   end

   assign ring_we    = (state == CAP_SAMPLE) && s_valid && !take;
   assign ring_waddr = wr_pos;
   assign ring_raddr = rd_pos;
   assign busy       = (state == CAP_COPY);
   assign copy_we    = (state == CAP_COPY);
   assign commit     = (state == CAP_COPY) && (remaining == LEN_W'(1));
   assign commit_len = len_hold;

endmodule

// File: rtl/event_store.sv
module event_store #(
   parameter int NUM_EVT     = 7,
   parameter int STORE_WORDS = 2048,
   parameter int WORD_W      = 24,
   parameter int LEN_W       = 11
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [WORD_W-1:0]                  wr_data,
   input  logic                               commit,
   input  logic [LEN_W-1:0]                   commit_len,
   input  logic                               rd_req,
   output logic [$clog2(NUM_EVT+1)-1:0]       evt_cnt,
   output logic [$clog2(STORE_WORDS):0]       free_words,
   output logic                               evt_ready,
   output logic                               rd_valid,
   output logic [WORD_W-1:0]                  rd_data,
   output logic                               rd_last
);

   localparam int SW  = $clog2(STORE_WORDS);
   localparam int FW  = SW + 1;
   localparam int DPW = $clog2(NUM_EVT);
   localparam int EW  = $clog2(NUM_EVT + 1);
   localparam bit SLOTS_POW2 = ((NUM_EVT & (NUM_EVT - 1)) == 0);

   logic [WORD_W-1:0] words [STORE_WORDS];
   logic [LEN_W-1:0]  slot_len [NUM_EVT];

   logic [SW-1:0]     wr_ptr;
   logic [SW-1:0]     rd_ptr;
   logic [FW-1:0]     used;
   logic [DPW-1:0]    slot_wr;
   logic [DPW-1:0]    slot_rd;
   logic [DPW-1:0]    slot_wr_nxt;
   logic [DPW-1:0]    slot_rd_nxt;
   logic [LEN_W-1:0]  head_off;
   logic              fire;
   logic              head_done;

   generate
      if (SLOTS_POW2) begin : g_slot_bin
         assign slot_wr_nxt = slot_wr + DPW'(1);
         assign slot_rd_nxt = slot_rd + DPW'(1);
      end else begin : g_slot_mod
         assign slot_wr_nxt = (slot_wr == DPW'(NUM_EVT - 1)) ? '0 : slot_wr + DPW'(1);
         assign slot_rd_nxt = (slot_rd == DPW'(NUM_EVT - 1)) ? '0 : slot_rd + DPW'(1);
      end
   endgenerate

   assign evt_ready  = (evt_cnt != '0);
   assign fire       = rd_req && evt_ready;
   assign head_done  = (head_off == slot_len[slot_rd] - LEN_W'(1));
   assign free_words = FW'(STORE_WORDS) - used;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         words[wr_ptr] <= wr_data;
      end
      if (commit) begin
         slot_len[slot_wr] <= commit_len;
      end
      if (fire) begin
         rd_data <= words[rd_ptr];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         used     <= '0;
         slot_wr  <= '0;
         slot_rd  <= '0;
         evt_cnt  <= '0;
         head_off <= '0;
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
      end else begin
         rd_valid <= fire;
         rd_last  <= fire && head_done;
         if (wr_en) begin
            wr_ptr <= wr_ptr + SW'(1);
         end
         if (fire) begin
            rd_ptr <= rd_ptr + SW'(1);
            if (head_done) begin
               head_off <= '0;
               slot_rd  <= slot_rd_nxt;
            end else begin
               head_off <= head_off + LEN_W'(1);
            end
         end
         if (commit) begin
            slot_wr <= slot_wr_nxt;
         end
         if (wr_en && !fire) begin
            used <= used + FW'(1);
         end else if (!wr_en && fire) begin
            used <= used - FW'(1);
         end
         if (commit && !(fire && head_done)) begin
            evt_cnt <= evt_cnt + EW'(1);
         end else if (!commit && fire && head_done) begin
            evt_cnt <= evt_cnt - EW'(1);
         end
      end
   end

endmodule

// File: rtl/ring_capture_ctrl.sv
module ring_capture_ctrl
   import ring_capture_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int SAMPLE_W    = 12,
   parameter int DEPTH       = 1024,
   parameter int NUM_EVT     = 7,
   parameter int STORE_WORDS = 2048,
   parameter int LOST_W      = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         s_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0]   s_data,
   input  logic                         trig,
   input  logic [$clog2(DEPTH):0]       rec_len,
   input  logic                         rd_req,
   output logic                         busy,
   output logic                         evt_ready,
   output logic                         rd_valid,
   output logic [NUM_CH*SAMPLE_W-1:0]   rd_data,
   output logic                         rd_last,
   output logic [LOST_W-1:0]            lost_cnt
);

   localparam int AW     = $clog2(DEPTH);
   localparam int LEN_W  = AW + 1;
   localparam int WORD_W = NUM_CH * SAMPLE_W;
   localparam int FW     = $clog2(STORE_WORDS) + 1;
   localparam int EW     = $clog2(NUM_EVT + 1);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ring_capture_ctrl: DEPTH must be a power of two of at least 4");
      end
      if (STORE_WORDS < DEPTH || (STORE_WORDS & (STORE_WORDS - 1)) != 0) begin : g_bad_store
         $error("ring_capture_ctrl: STORE_WORDS must be a power of two not below DEPTH");
      end
      if (NUM_EVT < 2) begin : g_bad_evt
         $error("ring_capture_ctrl: NUM_EVT must be at least 2");
      end
      if (NUM_CH < 1 || SAMPLE_W < 1 || LOST_W < 1) begin : g_bad_width
         $error("ring_capture_ctrl: channel count and widths must be positive");
      end
   endgenerate

   logic               ring_we;
   logic [AW-1:0]      ring_waddr;
   logic [AW-1:0]      ring_raddr;
   logic [WORD_W-1:0]  ring_q;
   logic               copy_we;
   logic               commit;
   logic [LEN_W-1:0]   commit_len;
   logic [EW-1:0]      evt_cnt;
   logic [FW-1:0]      free_words;

   ring_bank #(
      .NUM_CH   (NUM_CH),
      .SAMPLE_W (SAMPLE_W),
      .DEPTH    (DEPTH)
   ) u_ring (
      .clk      (clk),
      .wr_en    (ring_we),
      .wr_addr  (ring_waddr),
      .wr_data  (s_data),
      .rd_addr  (ring_raddr),
      .rd_data  (ring_q)
   );

   capture_fsm #(
      .DEPTH       (DEPTH),
      .NUM_EVT     (NUM_EVT),
      .STORE_WORDS (STORE_WORDS),
      .LOST_W      (LOST_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .s_valid     (s_valid),
      .trig        (trig),
      .rec_len     (rec_len),
      .evt_cnt     (evt_cnt),
      .free_words  (free_words),
      .ring_we     (ring_we),
      .ring_waddr  (ring_waddr),
      .ring_raddr  (ring_raddr),
      .busy        (busy),
      .copy_we     (copy_we),
      .commit      (commit),
      .commit_len  (commit_len),
      .lost_cnt    (lost_cnt)
   );

   event_store #(
      .NUM_EVT     (NUM_EVT),
      .STORE_WORDS (STORE_WORDS),
      .WORD_W      (WORD_W),
      .LEN_W       (LEN_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (copy_we),
      .wr_data     (ring_q),
      .commit      (commit),
      .commit_len  (commit_len),
      .rd_req      (rd_req),
      .evt_cnt     (evt_cnt),
      .free_words  (free_words),
      .evt_ready   (evt_ready),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .rd_last     (rd_last)
   );

endmodule

// File: rtl/ring_capture_chk.sv
module ring_capture_chk #(
   parameter int LOST_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig,
   input logic              busy,
   input logic              evt_ready,
   input logic              rd_req,
   input logic              rd_valid,
   input logic              rd_last,
   input logic [LOST_W-1:0] lost_cnt
);

   AST_BUSY_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(trig)); // R4

   AST_DEAD_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(lost_cnt)); // R5

   AST_LOST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_cnt != $past(lost_cnt)) |-> (lost_cnt == $past(lost_cnt) + LOST_W'(1))); // R6

   AST_ACCEPT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $stable(lost_cnt)); // R6

   AST_READY_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ready && !rd_req) |=> evt_ready); // R7

   AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req && evt_ready)); // R8

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid); // R8

endmodule

bind ring_capture_ctrl ring_capture_chk #(.LOST_W(LOST_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig      (trig),
   .busy      (busy),
   .evt_ready (evt_ready),
   .rd_req    (rd_req),
   .rd_valid  (rd_valid),
   .rd_last   (rd_last),
   .lost_cnt  (lost_cnt)
);

// File: tb/tb_ring_capture_ctrl.sv
module tb_ring_capture_ctrl;

   localparam int DEPTH = 1024;
   localparam int NSLOT = 7;
   localparam int CAP   = 2048;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        s_valid;
   logic [23:0] s_data;
   logic        trig;
   logic [10:0] rec_len;
   logic        rd_req;
   logic        busy;
   logic        evt_ready;
   logic        rd_valid;
   logic [23:0] rd_data;
   logic        rd_last;
   logic [15:0] lost_cnt;

   int n_cmp = 0;
   int n_bad = 0;
   int wcnt = 0;
   int exp_lost = 0;
   int ev_start [16];
   int ev_len [16];
   int ev_head = 0;
   int ev_tail = 0;
   int ev_cnt = 0;
   int ev_words = 0;

   always #5 clk = ~clk;

   ring_capture_ctrl dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
      .trig(trig), .rec_len(rec_len), .rd_req(rd_req), .busy(busy),
      .evt_ready(evt_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_last(rd_last), .lost_cnt(lost_cnt)
   );

   function automatic logic [23:0] ramp_word(input int idx);
      logic [11:0] c0;
      logic [11:0] c1;
      int mix;
      mix = idx * 7 + 5;
      c0 = idx[11:0];
      c1 = mix[11:0];
      return {c1, c0};
   endfunction

   function automatic int eff_len(input int l);
      return (l == 0 || l > DEPTH) ? DEPTH : l;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input int n);
      for (int i = 0; i < n; i++) begin
         s_valid = 1'b1;
         s_data  = ramp_word(wcnt);
         @(negedge clk);
         wcnt++;
      end
      s_valid = 1'b0;
   endtask

   // Trigger with requested length l. with_s drives a sample in the trigger cycle (R11);
   // noise drives a sample and a trigger during the first dead cycle (R4, R5).
   task automatic fire_trig(input int l, input bit with_s, input bit noise);
      int  le;
      int  n;
      bit  acc;
      le  = eff_len(l);
      acc = (ev_cnt < NSLOT) && (CAP - ev_words >= le);
      trig    = 1'b1;
      rec_len = 11'(l);
      s_valid = with_s;
      s_data  = ramp_word(wcnt);
      @(negedge clk);
      if (with_s && !acc) wcnt++;
      check(busy == acc, "R6 trigger acceptance (busy)", busy, acc);
      n = 0;
      while (busy === 1'b1 && n < 3000) begin
         n++;
         if (noise && n == 1) begin
            s_valid = 1'b1;
            s_data  = 24'hABCDEF;
            trig    = 1'b1;
         end else begin
            s_valid = 1'b0;
            trig    = 1'b0;
         end
         @(negedge clk);
      end
      s_valid = 1'b0;
      trig    = 1'b0;
      if (acc) begin
         check(n == le, "R4 dead-time length", n, le);
         ev_start[ev_tail] = wcnt - le;
         ev_len[ev_tail]   = le;
         ev_tail = (ev_tail + 1) % 16;
         ev_cnt++;
         ev_words += le;
         check(evt_ready == 1'b1, "R7 ready after copy", evt_ready, 1);
      end else begin
         exp_lost++;
      end
      check(lost_cnt == 16'(exp_lost), "R5 R6 lost counter", lost_cnt, exp_lost);
   endtask

   task automatic read_event();
      int st;
      int le;
      logic [23:0] e;
      st = ev_start[ev_head];
      le = ev_len[ev_head];
      check(evt_ready == 1'b1, "R7 ready before read", evt_ready, 1);
      rd_req = 1'b1;
      for (int k = 0; k < le; k++) begin
         @(negedge clk);
         e = ramp_word(st + k);
         check(rd_valid == 1'b1, "R8 read valid", rd_valid, 1);
         check(rd_data == e, "R2 R9 window word", rd_data, e);
         check(rd_last == (k == le - 1), "R8 last flag", rd_last, (k == le - 1));
      end
      rd_req = 1'b0;
      ev_head = (ev_head + 1) % 16;
      ev_cnt--;
      ev_words -= le;
      @(negedge clk);
      check(rd_valid == 1'b0, "R8 no valid without request", rd_valid, 0);
      check(evt_ready == (ev_cnt > 0), "R7 ready tracks store", evt_ready, (ev_cnt > 0));
   endtask

   task automatic drain();
      while (ev_cnt > 0) read_event();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 200000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int l;
      int r;
      void'($urandom(32'h1F2E3D4C));
      rst_n = 1'b0; s_valid = 1'b0; s_data = '0; trig = 1'b0; rec_len = '0; rd_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(busy == 1'b0, "R10 busy after reset", busy, 0);
      check(evt_ready == 1'b0, "R10 ready after reset", evt_ready, 0);
      check(rd_valid == 1'b0, "R10 valid after reset", rd_valid, 0);
      check(lost_cnt == 16'd0, "R10 lost after reset", lost_cnt, 0);
      // R1 R10: write position starts at cell 0
      push(3);
      fire_trig(3, 1'b0, 1'b0);
      read_event();
      // R2: window crossing cell 1023 to 0
      push(1100);
      push((DEPTH - (wcnt % DEPTH) + 5) % DEPTH);
      fire_trig(20, 1'b0, 1'b0);
      read_event();
      // R3: length 0 and oversize length both mean full depth
      push(40);
      fire_trig(0, 1'b0, 1'b1);
      read_event();
      push(7);
      fire_trig(1500, 1'b1, 1'b0);
      read_event();
      // R6: seven slots full, eighth refused; R5 noise during dead time
      for (int i = 0; i < NSLOT; i++) begin
         push(3);
         fire_trig(8, 1'b0, i[0]);
      end
      push(2);
      fire_trig(8, 1'b1, 1'b0);
      drain();
      // R6: word capacity exhausted with only two events
      push(300);
      fire_trig(1024, 1'b0, 1'b0);
      push(10);
      fire_trig(1024, 1'b0, 1'b0);
      fire_trig(1, 1'b0, 1'b0);
      read_event();
      // R9: resume at frozen position, window spans the previous trigger
      push(1);
      fire_trig(2, 1'b0, 1'b0);
      drain();
      // R11 both ways mixed in random traffic
      for (int it = 0; it < 30; it++) begin
         push(1 + int'($urandom % 900));
         r = int'($urandom % 8);
         if (r == 0) l = 0;
         else if (r == 1) l = 1 + int'($urandom % 1024);
         else l = 1 + int'($urandom % 200);
         fire_trig(l, 1'($urandom % 2), 1'($urandom % 2));
         r = int'($urandom % 3);
         if (r == 0) drain();
         else if (r == 1 && ev_cnt > 0) read_event();
      end
      drain();
      check(evt_ready == 1'b0, "R7 empty at end", evt_ready, 0);
      check(lost_cnt == 16'(exp_lost), "R6 final lost count", lost_cnt, exp_lost);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule